// File: doc/BRIEF.md
# Load-Level CPU Clock Selector

This block sets the source and division of a processor clock from one of four performance levels. Each level owns a small slot holding a divider, a clock-select bit and a two-bit reference select. The slots are packed two to a 32-bit register. A two-bit current-level value chooses the active slot whenever dynamic scaling is switched on. With scaling off, a separate static register supplies the reference, clock select and divider instead.

The level changes only through requests. A level request names the target level. A rate request names a divider, and the block searches the slots for it. A parent request sets the reference select. A move to the fastest level (level 0) from one of the two slowest levels (2 or 3) is split into two steps. The block first goes to level 1 and holds there for a programmable number of settle cycles. Only then does it apply level 0. This gives the supply time to rise before the clock does.

Top module: `lvl_dvfs_ctrl`

## Requirements
- R1: Synchronous reset clears the following to zero: every register, the current level, `busy`, `req_err` and all three active outputs.
- R2: The register port works as follows.
  - Writes take effect at the clock edge. `reg_rdata` presents the register at `reg_addr` one cycle later.
  - Byte offset 0x18 holds levels 0 and 1. Offset 0x1C holds levels 2 and 3.
  - Within each of those registers, the even level sits in bits 31:16 and the odd level in bits 15:0.
  - Within each 16-bit slot, the divider is bits 15:13, the clock select is bit 11 and the reference select is bits 10:9. All other slot bits read as zero.
  - Offset 0x00 is the static register: reference select in bits 1:0, clock select in bit 4, divider in bits 10:8.
  - Offset 0x24 bit 31 enables scaling.
  - Offset 0x34 holds the settle count.
  - Offset 0x30 reads the current level in bits 1:0. Writes to 0x30 are ignored.
- R3: With scaling enabled, `act_ref`, `act_clk` and `act_div` take the fields of the current level's slot. They follow a change of level or slot one cycle later.
- R4: With scaling disabled, the active outputs take the static register's fields. A static divider code of 7 is presented as 0.
- R5: With scaling enabled and the block idle, a level request sets the current level to the target at the next edge, with `busy` low. The one exception is the case in R6.
- R6: A move to level 0 from level 2 or 3 works in three steps.
  - At the next edge, the level becomes 1 and `busy` rises.
  - Level 1 and `busy` are held for the settle count plus one cycles.
  - The level then becomes 0 at the same edge where `busy` falls.
- R7: A rate request searches levels 0, 1, 2 and 3 in that order. It targets the first level whose slot divider equals the requested divider. The move follows R5 and R6.
- R8: A rate request that matches no slot pulses `req_err` for one cycle and leaves the level unchanged.
- R9: Level and rate requests made while scaling is disabled pulse `req_err` and leave the level unchanged.
- R10: A parent request behaves according to the scaling state.
  - With scaling enabled, it pulses `req_err` and leaves every slot unchanged.
  - With scaling disabled, it writes the requested reference select into all four slots. The other slot fields are kept.
- R11: Level and rate requests that arrive while `busy` is high are ignored. They raise no error and do not change the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| lvl_req | input | 1 | Level request strobe |
| lvl_target | input | 2 | Requested level |
| rate_req | input | 1 | Rate request strobe |
| rate_div | input | 3 | Requested divider |
| par_req | input | 1 | Parent request strobe |
| par_sel | input | 2 | Requested reference select |
| cur_level | output | 2 | Current load level |
| busy | output | 1 | Settle step in progress |
| req_err | output | 1 | One-cycle pulse on a rejected request |
| act_ref | output | 2 | Active reference select |
| act_clk | output | 1 | Active clock select |
| act_div | output | 3 | Active divider |

## Verification
The bench runs every pair of source and target levels, at a settle count of zero and at a larger count.
- A design that jumps straight from a slow level to level 0 fails these checks.
- So does a design whose settle window is off by one cycle.

The bench also sweeps every static field value, including divider code 7. It sweeps every requested divider against slots that hold a repeated divider, so a search that takes the last match fails. Two further checks cover requests that should have no effect:
- Requests issued during the settle window must not disturb the sequence.
- A parent request made while scaling is enabled must leave every slot as it was.

// File: rtl/lvl_dvfs_pkg.sv
package lvl_dvfs_pkg;
  localparam int unsigned LVL_N  = 4;
  localparam int unsigned LVL_W  = 2;
  localparam int unsigned DIV_W  = 3;
  localparam int unsigned REF_W  = 2;
  localparam int unsigned SLOT_W = DIV_W + 1 + REF_W;   // {div, clk, ref}

  // field positions inside a 16-bit level slot
  localparam int unsigned HALF_SHIFT = 16;
  localparam int unsigned DIV_LSB    = 13;
  localparam int unsigned CSEL_BIT   = 11;
  localparam int unsigned REF_LSB    = 9;

  // static register fields
  localparam int unsigned ST_REF_LSB = 0;
  localparam int unsigned ST_CSEL    = 4;
  localparam int unsigned ST_DIV_LSB = 8;
  localparam int unsigned DYN_BIT    = 31;

  localparam logic [7:0] OFS_STATIC = 8'h00;
  localparam logic [7:0] OFS_PAIR01 = 8'h18;
  localparam logic [7:0] OFS_PAIR23 = 8'h1C;
  localparam logic [7:0] OFS_DYN    = 8'h24;
  localparam logic [7:0] OFS_LOAD   = 8'h30;
  localparam logic [7:0] OFS_SETTLE = 8'h34;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef enum logic {SQ_IDLE, SQ_SETTLE} sq_state_t;

  function automatic slot_t pick_slot(input logic [15:0] half);
    return {half[DIV_LSB +: DIV_W], half[CSEL_BIT], half[REF_LSB +: REF_W]};
  endfunction

  function automatic logic [15:0] spread_slot(input slot_t s);
    return {s[SLOT_W-1 -: DIV_W], 1'b0, s[REF_W], s[REF_W-1:0], 9'b0};
  endfunction
endpackage

// File: rtl/lvl_dvfs_regs.sv
module lvl_dvfs_regs
  import lvl_dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  input  logic                      bcast,
  input  logic [REF_W-1:0]          bcast_sel,
  input  logic [LVL_W-1:0]          cur_level,
  output logic [31:0]               rdata,
  output logic [LVL_N-1:0][SLOT_W-1:0] slots,
  output logic [REF_W-1:0]          stat_ref,
  output logic                      stat_clk,
  output logic [DIV_W-1:0]          stat_div,
  output logic                      dyn_en,
  output logic [CNT_W-1:0]          settle
);
  localparam logic [ADDR_W-1:0] A_STATIC = ADDR_W'(OFS_STATIC);
  localparam logic [ADDR_W-1:0] A_PAIR01 = ADDR_W'(OFS_PAIR01);
  localparam logic [ADDR_W-1:0] A_PAIR23 = ADDR_W'(OFS_PAIR23);
  localparam logic [ADDR_W-1:0] A_DYN    = ADDR_W'(OFS_DYN);
  localparam logic [ADDR_W-1:0] A_LOAD   = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_SETTLE = ADDR_W'(OFS_SETTLE);

  logic  unused_wdata;
  slot_t w_even, w_odd;
  logic [31:0] rd_n;

  assign unused_wdata = ^wdata;
  assign w_even = pick_slot(wdata[31:16]);
  assign w_odd  = pick_slot(wdata[15:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      slots    <= '0;
      stat_ref <= '0;
      stat_clk <= 1'b0;
      stat_div <= '0;
      dyn_en   <= 1'b0;
      settle   <= '0;
    end else begin
      for (int g = 0; g < LVL_N; g++) begin
        if (wr && addr == ((g < 2) ? A_PAIR01 : A_PAIR23))
          slots[g] <= (g % 2 == 0) ? w_even : w_odd;
        if (bcast)
          slots[g][REF_W-1:0] <= bcast_sel;
      end
      if (wr && addr == A_STATIC) begin
        stat_ref <= wdata[ST_REF_LSB +: REF_W];
        stat_clk <= wdata[ST_CSEL];
        stat_div <= wdata[ST_DIV_LSB +: DIV_W];
      end
      if (wr && addr == A_DYN)    dyn_en <= wdata[DYN_BIT];
      if (wr && addr == A_SETTLE) settle <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      A_STATIC: begin
        rd_n[ST_REF_LSB +: REF_W] = stat_ref;
        rd_n[ST_CSEL]             = stat_clk;
        rd_n[ST_DIV_LSB +: DIV_W] = stat_div;
      end
      A_PAIR01: rd_n = {spread_slot(slots[0]), spread_slot(slots[1])};
      A_PAIR23: rd_n = {spread_slot(slots[2]), spread_slot(slots[3])};
      A_DYN:    rd_n[DYN_BIT] = dyn_en;
      A_LOAD:   rd_n[LVL_W-1:0] = cur_level;
      A_SETTLE: rd_n = 32'(settle);
      default:  rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end
endmodule

// File: rtl/lvl_dvfs_seq.sv
module lvl_dvfs_seq
  import lvl_dvfs_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dyn_en,
  input  logic                         lvl_req,
  input  logic [LVL_W-1:0]             lvl_target,
  input  logic                         rate_req,
  input  logic [DIV_W-1:0]             rate_div,
  input  logic                         par_req,
  input  logic [CNT_W-1:0]             settle,
  input  logic [LVL_N-1:0][DIV_W-1:0]  lvl_divs,
  output logic [LVL_W-1:0]             cur_level,
  output logic                         busy,
  output logic                         req_err,
  output logic                         bcast
);
  sq_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [LVL_N-1:0] match;
  logic [LVL_W-1:0] hit_lvl, tgt;
  logic             go, err_n;

  for (genvar g = 0; g < LVL_N; g++) begin : g_match
    assign match[g] = (lvl_divs[g] == rate_div);
  end

  always_comb begin
    hit_lvl = '0;
    for (int i = LVL_N - 1; i >= 0; i--)
      if (match[i]) hit_lvl = LVL_W'(i);
  end

  always_comb begin
    go = 1'b0; tgt = '0; err_n = 1'b0; bcast = 1'b0;
    if (state == SQ_IDLE) begin
      if (lvl_req) begin
        if (dyn_en) begin go = 1'b1; tgt = lvl_target; end
        else err_n = 1'b1;
      end else if (rate_req) begin
        if (dyn_en && |match) begin go = 1'b1; tgt = hit_lvl; end
        else err_n = 1'b1;
      end else if (par_req) begin
        if (dyn_en) err_n = 1'b1;
        else bcast = 1'b1;
      end
    end
  end

  assign busy = (state == SQ_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cur_level <= '0;
      cnt       <= '0;
      req_err   <= 1'b0;
    end else begin
      req_err <= err_n;
      case (state)
        SQ_IDLE: if (go) begin
          if (tgt == '0 && cur_level[LVL_W-1]) begin
            cur_level <= LVL_W'(1);
            cnt       <= settle;
            state     <= SQ_SETTLE;
          end else begin
            cur_level <= tgt;
          end
        end
        SQ_SETTLE: begin
          if (cnt == '0) begin
            cur_level <= '0;
            state     <= SQ_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lvl_dvfs_sel.sv
module lvl_dvfs_sel
  import lvl_dvfs_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dyn_en,
  input  logic [LVL_N-1:0][SLOT_W-1:0] slots,
  input  logic [LVL_W-1:0]             cur_level,
  input  logic [REF_W-1:0]             stat_ref,
  input  logic                         stat_clk,
  input  logic [DIV_W-1:0]             stat_div,
  output logic [REF_W-1:0]             act_ref,
  output logic                         act_clk,
  output logic [DIV_W-1:0]             act_div
);
  slot_t cur_slot;
  assign cur_slot = slots[cur_level];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_ref <= '0; act_clk <= 1'b0; act_div <= '0;
    end else if (dyn_en) begin
      act_ref <= cur_slot[REF_W-1:0];
      act_clk <= cur_slot[REF_W];
      act_div <= cur_slot[SLOT_W-1 -: DIV_W];
    end else begin
      act_ref <= stat_ref;
      act_clk <= stat_clk;
      act_div <= (stat_div == '1) ? '0 : stat_div;
    end
  end
endmodule

// File: rtl/lvl_dvfs_ctrl.sv
module lvl_dvfs_ctrl
  import lvl_dvfs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lvl_req,
  input  logic [1:0]        lvl_target,
  input  logic              rate_req,
  input  logic [2:0]        rate_div,
  input  logic              par_req,
  input  logic [1:0]        par_sel,
  output logic [1:0]        cur_level,
  output logic              busy,
  output logic              req_err,
  output logic [1:0]        act_ref,
  output logic              act_clk,
  output logic [2:0]        act_div
);
  logic [LVL_N-1:0][SLOT_W-1:0] slots;
  logic [LVL_N-1:0][DIV_W-1:0]  lvl_divs;
  logic [REF_W-1:0]             stat_ref;
  logic                         stat_clk;
  logic [DIV_W-1:0]             stat_div;
  logic                         dyn_en, bcast;
  logic [CNT_W-1:0]             settle;

  for (genvar g = 0; g < LVL_N; g++) begin : g_divs
    assign lvl_divs[g] = slots[g][SLOT_W-1 -: DIV_W];
  end

  lvl_dvfs_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .bcast(bcast), .bcast_sel(par_sel), .cur_level(cur_level),
    .rdata(reg_rdata), .slots(slots), .stat_ref(stat_ref),
    .stat_clk(stat_clk), .stat_div(stat_div), .dyn_en(dyn_en), .settle(settle)
  );

  lvl_dvfs_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst), .dyn_en(dyn_en), .lvl_req(lvl_req),
    .lvl_target(lvl_target), .rate_req(rate_req), .rate_div(rate_div),
    .par_req(par_req), .settle(settle), .lvl_divs(lvl_divs),
    .cur_level(cur_level), .busy(busy), .req_err(req_err), .bcast(bcast)
  );

  lvl_dvfs_sel sel_i (
    .clk(clk), .rst(rst), .dyn_en(dyn_en), .slots(slots),
    .cur_level(cur_level), .stat_ref(stat_ref), .stat_clk(stat_clk),
    .stat_div(stat_div), .act_ref(act_ref), .act_clk(act_clk),
    .act_div(act_div)
  );
endmodule

// File: rtl/lvl_dvfs_chk.sv
module lvl_dvfs_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cur_level,
  input logic       busy,
  input logic       req_err
);
  AST_SETTLE_AT_ONE: assert property (@(posedge clk) disable iff (rst)
    busy |-> cur_level == 2'd1); // R6
  AST_NO_DIRECT_DROP: assert property (@(posedge clk) disable iff (rst)
    (cur_level == 2'd0 && $past(cur_level) != 2'd0) |-> $past(cur_level) == 2'd1); // R6
  AST_BUSY_ENDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cur_level == 2'd0); // R6
  AST_BUSY_FROM_SLOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cur_level) >= 2'd2); // R6
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !req_err); // R11
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    req_err |-> cur_level == $past(cur_level)); // R8
endmodule

bind lvl_dvfs_ctrl lvl_dvfs_chk chk_i (
  .clk(clk), .rst(rst), .cur_level(cur_level), .busy(busy), .req_err(req_err)
);

// File: tb/lvl_dvfs_ctrl_tb_top.sv
module lvl_dvfs_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAIR_MASK = 32'hEE00_EE00;
  localparam logic [31:0] STAT_MASK = 32'h0000_0713;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lvl_req = 1'b0, rate_req = 1'b0, par_req = 1'b0;
  logic [1:0]  lvl_target = '0, par_sel = '0;
  logic [2:0]  rate_div = '0;
  logic [1:0]  cur_level, act_ref;
  logic        busy, req_err, act_clk;
  logic [2:0]  act_div;

  int checks = 0, errors = 0;
  logic [31:0] m_lo = '0, m_hi = '0, m_stat = '0;
  logic        m_en = 1'b0;
  int          m_settle = 0, m_lvl = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_dvfs_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_req(lvl_req),
    .lvl_target(lvl_target), .rate_req(rate_req), .rate_div(rate_div),
    .par_req(par_req), .par_sel(par_sel), .cur_level(cur_level),
    .busy(busy), .req_err(req_err), .act_ref(act_ref), .act_clk(act_clk),
    .act_div(act_div)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
    case (a)
      8'h00: m_stat = d & STAT_MASK;
      8'h18: m_lo = d & PAIR_MASK;
      8'h1C: m_hi = d & PAIR_MASK;
      8'h24: m_en = d[31];
      8'h34: m_settle = int'(d[15:0]);
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    step();
    chk(tag, reg_rdata, exp);
  endtask

  task automatic chk_act(input string tag);
    logic [31:0] w, h;
    int e_ref, e_clk, e_div;
    step(); step();
    if (m_en) begin
      w = (m_lvl < 2) ? m_lo : m_hi;
      h = (m_lvl % 2 == 0) ? (w >> 16) : (w & 32'hFFFF);
      e_div = int'((h >> 13) & 7); e_clk = int'((h >> 11) & 1); e_ref = int'((h >> 9) & 3);
    end else begin
      e_ref = int'(m_stat & 3); e_clk = int'((m_stat >> 4) & 1);
      e_div = int'((m_stat >> 8) & 7);
      if (e_div == 7) e_div = 0;
    end
    chk({tag, " ref"}, 32'(act_ref), 32'(e_ref));
    chk({tag, " clk"}, 32'(act_clk), 32'(e_clk));
    chk({tag, " div"}, 32'(act_div), 32'(e_div));
  endtask

  // kind 0 level, 1 rate, 2 parent
  task automatic go_req(input int kind, input int val, input int exp_lvl,
                        input bit exp_err, input string tag);
    case (kind)
      0: begin lvl_req = 1'b1; lvl_target = 2'(val); end
      1: begin rate_req = 1'b1; rate_div = 3'(val); end
      default: begin par_req = 1'b1; par_sel = 2'(val); end
    endcase
    step();
    lvl_req = 1'b0; rate_req = 1'b0; par_req = 1'b0;
    chk({tag, " err"}, 32'(req_err), 32'(exp_err));
    if (kind != 2) begin
      if (exp_err) begin
        chk({tag, " level kept"}, 32'(cur_level), 32'(m_lvl));
      end else if (exp_lvl == 0 && m_lvl >= 2) begin
        for (int i = 0; i <= m_settle; i++) begin
          chk({tag, " R6 busy"}, 32'(busy), 32'd1);
          chk({tag, " R6 mid level"}, 32'(cur_level), 32'd1);
          step();
        end
        chk({tag, " R6 busy end"}, 32'(busy), 32'd0);
        chk({tag, " R6 final"}, 32'(cur_level), 32'd0);
        m_lvl = 0;
      end else begin
        chk({tag, " R5 level"}, 32'(cur_level), 32'(exp_lvl));
        chk({tag, " R5 busy"}, 32'(busy), 32'd0);
        m_lvl = exp_lvl;
      end
    end
  endtask

  function automatic logic [31:0] slot_half(input int div, input int c, input int r);
    return 32'((div << 13) | (c << 11) | (r << 9) | 32'h11FF);
  endfunction

  function automatic logic [31:0] set_ref(input logic [31:0] w, input int r);
    return (w & ~32'h0600_0600) | 32'(r << 25) | 32'(r << 9);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    logic [31:0] lo_save, hi_save;
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 level", 32'(cur_level), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 err", 32'(req_err), 0);
    chk("R1 act", {27'b0, act_ref, act_clk, act_div}, 0);
    rd_chk(8'h24, 32'h0, "R1 dyn reg");
    rd_chk(8'h34, 32'h0, "R1 settle reg");

    // R2 register port
    wr_reg(8'h18, 32'hA5A5_1234);
    wr_reg(8'h1C, 32'h5A5A_EDCB);
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h34, 32'd7);
    wr_reg(8'h30, 32'h3);
    rd_chk(8'h18, m_lo, "R2 pair01");
    rd_chk(8'h1C, m_hi, "R2 pair23");
    rd_chk(8'h00, m_stat, "R2 static");
    rd_chk(8'h34, 32'd7, "R2 settle");
    rd_chk(8'h30, 32'h0, "R2 load write ignored");
    wr_reg(8'h24, 32'hFFFF_FFFF);
    rd_chk(8'h24, 32'h8000_0000, "R2 dyn");
    wr_reg(8'h24, 32'h0);

    // R4 static sweep
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 2; c++)
        for (int d = 0; d < 8; d++) begin
          wr_reg(8'h00, 32'hFFFF_F8EC | 32'(r) | 32'(c << 4) | 32'(d << 8));
          chk_act("R4 static");
        end

    // R9 requests while disabled
    go_req(0, 2, 0, 1'b1, "R9 level");
    go_req(1, 0, 0, 1'b1, "R9 rate");

    // R10 parent broadcast while disabled
    go_req(2, 2, 0, 1'b0, "R10 bcast");
    m_lo = set_ref(m_lo, 2); m_hi = set_ref(m_hi, 2);
    rd_chk(8'h18, m_lo, "R10 bcast pair01");
    rd_chk(8'h1C, m_hi, "R10 bcast pair23");

    // enable scaling, R10 rejected
    wr_reg(8'h24, 32'h8000_0000);
    lo_save = m_lo; hi_save = m_hi;
    go_req(2, 1, 0, 1'b1, "R10 rejected");
    rd_chk(8'h18, lo_save, "R10 pair01 kept");
    rd_chk(8'h1C, hi_save, "R10 pair23 kept");

    // R3 R5 R6: per-level slot contents, all from/to pairs, two settle counts
    wr_reg(8'h18, (slot_half(1, 1, 3) << 16) | slot_half(4, 0, 0));
    wr_reg(8'h1C, (slot_half(7, 1, 1) << 16) | slot_half(2, 0, 2));
    for (int pass = 0; pass < 2; pass++) begin
      wr_reg(8'h34, pass == 0 ? 32'd0 : 32'd3);
      for (int f = 0; f < 4; f++)
        for (int t = 0; t < 4; t++) begin
          go_req(0, f, f, 1'b0, "R5 setup");
          chk_act("R3 from");
          go_req(0, t, t, 1'b0, "R6 move");
          chk_act("R3 to");
          rd_chk(8'h30, 32'(t), "R2 load readback");
        end
    end

    // R7 R8 rate search with slot dividers {4,6,4,2}
    wr_reg(8'h34, 32'd2);
    wr_reg(8'h18, (slot_half(4, 0, 1) << 16) | slot_half(6, 1, 2));
    wr_reg(8'h1C, (slot_half(4, 1, 3) << 16) | slot_half(2, 0, 0));
    for (int t = 0; t < 8; t++) begin
      go_req(0, 3, 3, 1'b0, "R7 setup");
      e = -1;
      for (int l = 3; l >= 0; l--)
        if (((((l < 2) ? m_lo : m_hi) >> ((l % 2 == 0) ? 29 : 13)) & 7) == 32'(t)) e = l;
      if (e < 0) go_req(1, t, 3, 1'b1, "R8 no match");
      else begin
        go_req(1, t, e, 1'b0, "R7 first match");
        chk_act("R7 outputs");
      end
    end

    // R11 requests while busy are ignored
    wr_reg(8'h34, 32'd6);
    go_req(0, 3, 3, 1'b0, "R11 setup");
    lvl_req = 1'b1; lvl_target = 2'd0; step(); lvl_req = 1'b0;
    chk("R11 busy started", 32'(busy), 1);
    lvl_req = 1'b1; lvl_target = 2'd2; step(); lvl_req = 1'b0;
    chk("R11 level req ignored err", 32'(req_err), 0);
    chk("R11 level req ignored level", 32'(cur_level), 1);
    rate_req = 1'b1; rate_div = 3'd2; step(); rate_req = 1'b0;
    chk("R11 rate req ignored err", 32'(req_err), 0);
    chk("R11 rate req ignored level", 32'(cur_level), 1);
    for (int i = 0; i < 20 && busy; i++) step();
    chk("R11 final level", 32'(cur_level), 0);
    chk("R11 idle", 32'(busy), 0);
    m_lvl = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule